// File: doc/BRIEF.md
# Two-Key Register Write Unlock Gate

This block sits between a simple register-bus slave port and a peripheral's protected register file. It guards every write to that file. After reset the gate is shut, and a write aimed at a protected address never reaches the file. Software opens the gate with two 32-bit key writes. The first key goes to its own key register and the second key goes to a separate key register. While the gate is open, each bus write to a non-key address raises a single write-enable strobe toward the protected file in the same cycle. A plain write of any non-key value to the first key register shuts the gate again.

The two key registers are not themselves protected. The only thing they hold is the progress of the unlock sequence, so they never raise the write strobe. A small demo register at one protected address stands in for the real register file, so the gating can be seen at the ports. Reads are combinational and do not depend on the gate: the demo address returns its current contents and every other address returns zero.

Top module: `reg_write_gate`

## Requirements
- R1: After reset the gate is shut. A reset applied while the gate is open also shuts it, and it clears the demo register to 0.
- R2: Writing 0x83E70B13 to the first key register (offset 0x6C) and then 0x95A4F1E0 to the second key register (offset 0x70) opens the gate. From the next cycle, writes to protected addresses raise `protWrEn` and update the demo register (offset 0x00).
- R3: A correct second key written while the first key has not been accepted leaves the gate shut.
- R4: Writing any value other than 0x83E70B13 to the first key register returns the sequence to its start. A following correct second key then does not open the gate.
- R5: Writing any value other than 0x95A4F1E0 to the second key register returns the sequence to its start. This holds both when the sequence is half done and when the gate is already open.
- R6: While the gate is open, writing 0 to the first key register shuts it from the next cycle on.
- R7: While the gate is shut, protected writes are dropped: `protWrEn` stays low and the demo register keeps its value. Reads still return the current contents.
- R8: Writes to either key register never raise `protWrEn`. A correct first key written while the gate is open leaves it open.
- R9: Writes to other addresses between the two key writes neither break the sequence nor are accepted.
- R10: `protWrEn` is high only in a cycle where `busWrEn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write request this cycle |
| busAddr | input | 8 | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| protWrEn | output | 1 | Write enable to the protected register file |

## Verification
A wrong gate state shows up at the first protected write that follows it. If the state is wrongly open, `protWrEn` rises and the demo register takes the data on that same edge, and the demo read shows it from the next cycle. If the state is wrongly shut, the strobe is missing and the old contents stay visible. The stimulus therefore follows each key sequence, whether accepted or broken, with a demo write and a demo read. That way every sequence path is exposed within two cycles.

// File: rtl/reg_write_gate_pkg.sv
package reg_write_gate_pkg;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_OPEN   = 2'd2
  } gateState_t;

  // decoded bus events, datapath -> control
  typedef struct packed {
    logic wrKickA;
    logic wrKickB;
    logic keyAMatch;
    logic keyBMatch;
    logic wrPlain;
  } busEvent_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic demoWr;
  } gateStrobe_t;

endpackage

// File: rtl/reg_write_gate_dp.sv
module reg_write_gate_dp
  import reg_write_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK_A_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK_B_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] DEMO_OFS = 8'h00,
  parameter logic [DATA_W-1:0] KEY_A = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  gateStrobe_t       strobe,
  output busEvent_t         busEvent,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] demoQ
);

  logic isKickA;
  logic isKickB;
  logic isDemo;

  assign isKickA = (busAddr == KICK_A_OFS);
  assign isKickB = (busAddr == KICK_B_OFS);
  assign isDemo  = (busAddr == DEMO_OFS);

  always_comb begin
    busEvent.wrKickA   = busWrEn && isKickA;
    busEvent.wrKickB   = busWrEn && isKickB;
    busEvent.keyAMatch = (busWrData == KEY_A);
    busEvent.keyBMatch = (busWrData == KEY_B);
    busEvent.wrPlain   = busWrEn && !isKickA && !isKickB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      demoQ <= '0;
    end else if (strobe.demoWr && isDemo) begin
      demoQ <= busWrData;
    end
  end

  assign busRdData = isDemo ? demoQ : '0;

endmodule

// File: rtl/reg_write_gate_ctrl.sv
module reg_write_gate_ctrl
  import reg_write_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   busEvent,
  output gateStrobe_t strobe,
  output logic        protWrEn,
  output logic        gateOpen
);

  gateState_t stateQ;
  gateState_t stateD;

  always_comb begin
    stateD = stateQ;
    if (busEvent.wrKickA) begin
      if (!busEvent.keyAMatch) begin
        stateD = GATE_LOCKED;
      end else if (stateQ != GATE_OPEN) begin
        stateD = GATE_ARMED;
      end
    end else if (busEvent.wrKickB) begin
      if (!busEvent.keyBMatch) begin
        stateD = GATE_LOCKED;
      end else if (stateQ == GATE_ARMED) begin
        stateD = GATE_OPEN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= GATE_LOCKED;
    end else begin
      stateQ <= stateD;
    end
  end

  assign gateOpen      = (stateQ == GATE_OPEN);
  assign protWrEn      = busEvent.wrPlain && gateOpen;
  assign strobe.demoWr = protWrEn;

endmodule

// File: rtl/reg_write_gate.sv
module reg_write_gate
  import reg_write_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK_A_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK_B_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] DEMO_OFS = 8'h00,
  parameter logic [DATA_W-1:0] KEY_A = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              protWrEn
);

  busEvent_t         busEvent;
  gateStrobe_t       strobe;
  logic              gateOpen;
  logic [DATA_W-1:0] demoQ;

  reg_write_gate_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KICK_A_OFS(KICK_A_OFS), .KICK_B_OFS(KICK_B_OFS), .DEMO_OFS(DEMO_OFS),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .busWrData(busWrData),
    .strobe(strobe),
    .busEvent(busEvent),
    .busRdData(busRdData),
    .demoQ(demoQ)
  );

  reg_write_gate_ctrl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .busEvent(busEvent),
    .strobe(strobe),
    .protWrEn(protWrEn),
    .gateOpen(gateOpen)
  );

endmodule

// File: rtl/reg_write_gate_chk.sv
module reg_write_gate_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK_A_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK_B_OFS = 8'h70,
  parameter logic [DATA_W-1:0] KEY_A = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B = 32'h95A4F1E0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              protWrEn,
  input logic              gateOpen,
  input logic [DATA_W-1:0] demoQ
);

  a_r1_reset_shuts: assert property (@(posedge clk)
    !rstN |=> !gateOpen);

  a_r10_strobe_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    protWrEn |-> busWrEn);

  a_r8_no_strobe_on_key: assert property (@(posedge clk) disable iff (!rstN)
    protWrEn |-> (busAddr != KICK_A_OFS && busAddr != KICK_B_OFS));

  a_r7_strobe_only_open: assert property (@(posedge clk) disable iff (!rstN)
    protWrEn |-> gateOpen);

  a_r6_relock_on_key_a: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == KICK_A_OFS && busWrData != KEY_A) |=> !gateOpen);

  a_r2_open_after_key_b: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> $past(busWrEn && busAddr == KICK_B_OFS && busWrData == KEY_B));

  a_r7_demo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !protWrEn |=> $stable(demoQ));

endmodule

bind reg_write_gate reg_write_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KICK_A_OFS(KICK_A_OFS), .KICK_B_OFS(KICK_B_OFS),
  .KEY_A(KEY_A), .KEY_B(KEY_B)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .busWrEn(busWrEn),
  .busAddr(busAddr),
  .busWrData(busWrData),
  .protWrEn(protWrEn),
  .gateOpen(gateOpen),
  .demoQ(demoQ)
);

// File: tb/reg_write_gate_test.sv
`timescale 1ns/1ps
module reg_write_gate_test;

  localparam logic [7:0]  OFS_A = 8'h6C;
  localparam logic [7:0]  OFS_B = 8'h70;
  localparam logic [7:0]  OFS_D = 8'h00;
  localparam logic [31:0] KA = 32'h83E70B13;
  localparam logic [31:0] KB = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        protWrEn;

  int compared = 0;
  int mismatched = 0;

  // reference model: 0 shut, 1 first key seen, 2 open
  int          mState = 0;
  logic [31:0] mDemo = '0;

  always #4 clk = ~clk;

  reg_write_gate uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .protWrEn(protWrEn)
  );

  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic rst, input string tag);
    logic        expWr;
    logic [31:0] expRd;
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; rstN = rst;
    #1;
    expWr = rst && we && a != OFS_A && a != OFS_B && mState == 2;
    expRd = (a == OFS_D) ? mDemo : 32'h0;
    compared++;
    if (protWrEn !== expWr) begin
      mismatched++;
      $display("FAIL %s protWrEn actual=%0b expected=%0b", tag, protWrEn, expWr);
    end
    compared++;
    if (busRdData !== expRd) begin
      mismatched++;
      $display("FAIL %s busRdData actual=%h expected=%h", tag, busRdData, expRd);
    end
    @(posedge clk);
    if (!rst) begin
      mState = 0; mDemo = '0;
    end else if (we) begin
      if (expWr && a == OFS_D) mDemo = d;
      if (a == OFS_A) begin
        if (d != KA) mState = 0;
        else if (mState != 2) mState = 1;
      end else if (a == OFS_B) begin
        if (d != KB) mState = 0;
        else if (mState == 1) mState = 2;
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cycle(1'b1, a, d, 1'b1, tag);
  endtask

  task automatic rd(input string tag);
    cycle(1'b0, OFS_D, 32'h0, 1'b1, tag);
  endtask

  initial begin
    fork
      begin
        cycle(1'b0, OFS_D, 32'h0, 1'b0, "R1 reset");
        cycle(1'b1, OFS_D, 32'h5555, 1'b0, "R1 reset");
        // R1 / R7: shut after reset, write dropped
        wr(OFS_D, 32'h1111_1111, "R7 locked write");
        rd("R1 demo after reset");
        // R3: second key alone
        wr(OFS_B, KB, "R3 lone key B");
        wr(OFS_D, 32'h2222_2222, "R3 still locked");
        rd("R3 read");
        // R2: correct sequence
        wr(OFS_A, KA, "R2 key A");
        wr(OFS_B, KB, "R2 key B");
        wr(OFS_D, 32'hCAFE_0001, "R2 open write");
        rd("R2 read");
        wr(8'h24, 32'h77, "R2 other protected addr");
        // R6: relock with 0
        wr(OFS_A, 32'h0, "R6 relock");
        wr(OFS_D, 32'hDEAD_BEEF, "R6 write after relock");
        rd("R7 contents kept");
        // R4: wrong first key breaks sequence
        wr(OFS_A, KA, "R4 key A");
        wr(OFS_A, 32'h1234, "R4 wrong A");
        wr(OFS_B, KB, "R4 key B");
        wr(OFS_D, 32'h4444, "R4 locked write");
        rd("R4 read");
        // R5: wrong second key breaks sequence
        wr(OFS_A, KA, "R5 key A");
        wr(OFS_B, 32'h95A4F1E1, "R5 wrong B");
        wr(OFS_B, KB, "R5 key B");
        wr(OFS_D, 32'h5555, "R5 locked write");
        rd("R5 read");
        // R9: intervening write
        wr(OFS_A, KA, "R9 key A");
        wr(OFS_D, 32'h9999, "R9 armed write dropped");
        wr(8'h40, 32'h1, "R9 other addr");
        wr(OFS_B, KB, "R9 key B");
        wr(OFS_D, 32'hABCD_0009, "R9 open write");
        rd("R9 read");
        // R8: key writes while open, no strobe, stays open
        wr(OFS_A, KA, "R8 key A while open");
        wr(OFS_B, KB, "R8 key B while open");
        wr(OFS_D, 32'h0808_0808, "R8 still open");
        // R10: no write, no strobe
        cycle(1'b0, 8'h24, 32'hFFFF, 1'b1, "R10 idle");
        rd("R10 read");
        // R5: wrong B while open locks
        wr(OFS_B, 32'h0, "R5 wrong B while open");
        wr(OFS_D, 32'h5050, "R5 locked after");
        rd("R5 read 2");
        // R1: reset while open
        wr(OFS_A, KA, "R1 key A");
        wr(OFS_B, KB, "R1 key B");
        cycle(1'b0, OFS_D, 32'h0, 1'b0, "R1 mid reset");
        wr(OFS_D, 32'h1010, "R1 locked after reset");
        rd("R1 demo cleared");
      end
      begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule